// File: doc/BRIEF.md
# Battery charge sequencing controller

This block sequences one charge cycle of a single lithium cell. It works from digitized comparator results: battery at the regulation voltage, battery above the fast-charge floor, battery under the recharge threshold, current under the end-of-charge level, and current-program input out of range. It also takes a periodic oscillator tick. From these it selects a charge mode, turns the pass element on or off, chooses the reduced trickle current, and drives two active-low indications. The analog loops, the comparators, the oscillator and thermal current reduction sit outside the block.

A cycle begins with a low-current trickle phase. The cell must stay above the fast-charge floor for a run of consecutive ticks before constant-current charging starts, and the trickle phase is bounded by one eighth of the safety time. Constant-current charging hands over to constant-voltage charging once the regulation voltage is reached. The end-of-charge indication is latched, but charging continues until the safety timer expires, and the block then rests in inhibit until the cell sags below the recharge threshold. If the timer expires before end-of-charge, the block latches a fault that only power-on reset or an enable toggle clears. An out-of-range program input pauses charging only for as long as it lasts.

All comparator inputs and the enable pass through two-flop synchronizers. The tick is a single-cycle strobe in the block's clock domain.

Top module: `chg_sequencer`

## Requirements
- R1: During and directly after power-on reset the block is idle: mode 0, charge off, trickle select low, statusN high, faultN high.
- R2: A charge cycle starts when the synchronized enable rises, when an inhibit ends on a recharge request, or when a program fault clears. It always starts in trickle (mode 1) with chargeOn high, trickleSel high and statusN low.
- R3: Trickle moves to constant current (mode 2) on the tick that completes QUAL_TICKS (default 15) consecutive ticks with the above-floor flag true. A tick with the flag false restarts the count.
- R4: If trickle lasts 2^(TIMER_W-3) ticks without qualifying, the block enters the timeout fault (mode 5) on that tick.
- R5: In constant current, a true at-regulation-voltage flag moves the block to constant voltage (mode 3).
- R6: In constant current or constant voltage, current below the end-of-charge level while the battery is not below the recharge threshold latches end-of-charge. statusN then goes high and stays high, while chargeOn stays high and the mode does not change.
- R7: End-of-charge is not qualified while the battery is below the recharge threshold, even if the current is low.
- R8: The safety timer restarts when constant current is entered. On the 2^TIMER_W-th tick spent in constant current and constant voltage, an end-of-charge cycle goes to inhibit (mode 4: charge off, both indications high).
- R9: If that timeout comes without end-of-charge, the block enters the timeout fault (mode 5: charge off, faultN low, statusN high). It stays there through ticks and program-fault activity until enable goes low.
- R10: In inhibit, a below-recharge flag starts a new cycle. This releases the end-of-charge latch and restarts the safety timer.
- R11: While the program-range fault flag is true, the block sits in mode 6 with charge off, faultN low and statusN high. When the flag clears, a new cycle starts in trickle.
- R12: Enable low forces idle (mode 0, charge off, both indications high) from any state, the timeout fault included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low power-on reset |
| oscTick | input | 1 | One-cycle strobe per oscillator period |
| enableIn | input | 1 | Charger enable, high to run (asynchronous) |
| atChargeV | input | 1 | Battery at or above the regulation voltage (asynchronous) |
| aboveMin | input | 1 | Battery above the fast-charge floor (asynchronous) |
| belowRecharge | input | 1 | Battery below the recharge threshold (asynchronous) |
| currentLow | input | 1 | Charge current below the end-of-charge level (asynchronous) |
| progFault | input | 1 | Current-program input out of range (asynchronous) |
| mode | output | 3 | 0 idle, 1 trickle, 2 constant current, 3 constant voltage, 4 inhibit, 5 timeout fault, 6 program fault |
| chargeOn | output | 1 | Pass element enabled |
| trickleSel | output | 1 | Reduced (one tenth) current selected |
| statusN | output | 1 | Low while charging before end-of-charge |
| faultN | output | 1 | Low in either fault mode |

## Verification
The trickle qualifier gets an interrupted run: ten good ticks, one bad tick, then fourteen good ticks. It must not advance, and one more good tick must advance it. This separates a consecutive count from a cumulative one. The cell also charges through two full cycles, one that reaches end-of-charge and one that does not. Each is stopped one tick short of the timeout and then given the final tick. This tells inhibit apart from the timeout fault and shows the timer restart exactly. A low current with the battery still under the recharge threshold shows that both conditions are required for end-of-charge. Program-fault pulses and enable toggles applied inside the latched fault show which inputs release it.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_TRICKLE = 3'd1,
    MODE_CC      = 3'd2,
    MODE_CV      = 3'd3,
    MODE_INHIBIT = 3'd4,
    MODE_TOFAULT = 3'd5,
    MODE_PGFAULT = 3'd6
  } chgMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic qualClr;
    logic qualRun;
  } dpCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic qualDone;
    logic trickleExpire;
    logic timeout;
  } dpEvt_t;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/chg_datapath.sv
module chg_datapath
  import chg_seq_pkg::*;
#(
  parameter int TIMER_W    = 22,
  parameter int QUAL_TICKS = 15
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   oscTick,
  input  logic   aboveMinS,
  input  dpCmd_t cmd,
  output dpEvt_t evt
);

  localparam int QUAL_W = $clog2(QUAL_TICKS + 1);
  localparam logic [QUAL_W-1:0] QUAL_LAST = QUAL_W'(QUAL_TICKS - 1);

  logic [TIMER_W-1:0] safetyTimer;
  logic [TIMER_W-1:0] timerNext;
  logic [QUAL_W-1:0]  qualCount;

  assign timerNext = safetyTimer + TIMER_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         safetyTimer <= '0;
    else if (cmd.timerClr)             safetyTimer <= '0;
    else if (cmd.timerRun && oscTick)  safetyTimer <= timerNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      qualCount <= '0;
    else if (cmd.qualClr)           qualCount <= '0;
    else if (cmd.qualRun && oscTick) begin
      if (!aboveMinS)                   qualCount <= '0;
      else if (qualCount != QUAL_LAST)  qualCount <= qualCount + QUAL_W'(1);
    end
  end

  always_comb begin
    evt.qualDone      = cmd.qualRun && oscTick && aboveMinS && (qualCount == QUAL_LAST);
    // trickle limit: any of the top three timer bits set after this tick
    evt.trickleExpire = cmd.timerRun && oscTick && (timerNext[TIMER_W-1 -: 3] != 3'b000);
    evt.timeout       = cmd.timerRun && oscTick && (&safetyTimer);
  end

endmodule

// File: rtl/chg_control.sv
module chg_control
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enS,
  input  logic       atCvS,
  input  logic       belowRechS,
  input  logic       curLowS,
  input  logic       progS,
  input  dpEvt_t     evt,
  output dpCmd_t     cmd,
  output logic [2:0] mode,
  output logic       chargeOn,
  output logic       trickleSel,
  output logic       statusN,
  output logic       faultN
);

  chgMode_e state, nextState;
  logic     eocLatch, enPrev;
  logic     enRise, startCycle, enterCc, eocNow, eocAny;
  logic     nextCharging;

  assign enRise = enS && !enPrev;
  assign eocNow = ((state == MODE_CC) || (state == MODE_CV)) && curLowS && !belowRechS;
  assign eocAny = eocLatch || eocNow;

  always_comb begin
    nextState  = state;
    startCycle = 1'b0;
    enterCc    = 1'b0;
    if (!enS) begin
      nextState = MODE_IDLE;
    end else if (state == MODE_TOFAULT) begin
      nextState = MODE_TOFAULT;
    end else if (progS) begin
      nextState = MODE_PGFAULT;
    end else begin
      unique case (state)
        MODE_IDLE: if (enRise) begin
          nextState  = MODE_TRICKLE;
          startCycle = 1'b1;
        end
        MODE_PGFAULT: begin
          nextState  = MODE_TRICKLE;
          startCycle = 1'b1;
        end
        MODE_TRICKLE: begin
          if (evt.qualDone) begin
            nextState = MODE_CC;
            enterCc   = 1'b1;
          end else if (evt.trickleExpire) begin
            nextState = MODE_TOFAULT;
          end
        end
        MODE_CC, MODE_CV: begin
          if (evt.timeout)                      nextState = eocAny ? MODE_INHIBIT : MODE_TOFAULT;
          else if (state == MODE_CC && atCvS)   nextState = MODE_CV;
        end
        MODE_INHIBIT: if (belowRechS) begin
          nextState  = MODE_TRICKLE;
          startCycle = 1'b1;
        end
        default: nextState = MODE_IDLE;
      endcase
    end
  end

  assign nextCharging = (nextState == MODE_TRICKLE) || (nextState == MODE_CC) || (nextState == MODE_CV);

  always_comb begin
    cmd.timerRun = (state == MODE_TRICKLE) || (state == MODE_CC) || (state == MODE_CV);
    cmd.timerClr = !nextCharging || startCycle || enterCc;
    cmd.qualRun  = (state == MODE_TRICKLE);
    cmd.qualClr  = (nextState != MODE_TRICKLE) || startCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= MODE_IDLE;
      eocLatch <= 1'b0;
      enPrev   <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= enS;
      if (startCycle || nextState == MODE_IDLE) eocLatch <= 1'b0;
      else if (eocNow)                           eocLatch <= 1'b1;
    end
  end

  always_comb begin
    mode       = state;
    chargeOn   = (state == MODE_TRICKLE) || (state == MODE_CC) || (state == MODE_CV);
    trickleSel = (state == MODE_TRICKLE);
    statusN    = !(chargeOn && !eocLatch);
    faultN     = !((state == MODE_TOFAULT) || (state == MODE_PGFAULT));
  end

endmodule

// File: rtl/chg_sequencer.sv
module chg_sequencer
  import chg_seq_pkg::*;
#(
  parameter int TIMER_W     = 22,
  parameter int QUAL_TICKS  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       enableIn,
  input  logic       atChargeV,
  input  logic       aboveMin,
  input  logic       belowRecharge,
  input  logic       currentLow,
  input  logic       progFault,
  output logic [2:0] mode,
  output logic       chargeOn,
  output logic       trickleSel,
  output logic       statusN,
  output logic       faultN
);

  localparam int N_SYNC = 6;

  logic [N_SYNC-1:0] syncBus;
  logic enSync, atCvSync, aboveMinSync, belowRechSync, curLowSync, progSync;
  dpCmd_t dpCmd;
  dpEvt_t dpEvt;

  chg_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({enableIn, atChargeV, aboveMin, belowRecharge, currentLow, progFault}),
    .syncOut (syncBus)
  );

  assign {enSync, atCvSync, aboveMinSync, belowRechSync, curLowSync, progSync} = syncBus;

  chg_datapath #(.TIMER_W(TIMER_W), .QUAL_TICKS(QUAL_TICKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .oscTick   (oscTick),
    .aboveMinS (aboveMinSync),
    .cmd       (dpCmd),
    .evt       (dpEvt)
  );

  chg_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enS        (enSync),
    .atCvS      (atCvSync),
    .belowRechS (belowRechSync),
    .curLowS    (curLowSync),
    .progS      (progSync),
    .evt        (dpEvt),
    .cmd        (dpCmd),
    .mode       (mode),
    .chargeOn   (chargeOn),
    .trickleSel (trickleSel),
    .statusN    (statusN),
    .faultN     (faultN)
  );

endmodule

// File: rtl/chg_sequencer_chk.sv
module chg_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       oscTick,
  input logic       enSync,
  input logic       progSync,
  input logic [2:0] mode,
  input logic       chargeOn,
  input logic       trickleSel,
  input logic       statusN,
  input logic       faultN
);

  p_cycle_starts_trickle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chargeOn) |-> trickleSel);

  p_qual_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(trickleSel) && chargeOn) |-> $past(oscTick));

  p_eoc_keeps_charging_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusN) && chargeOn && $past(chargeOn)) |-> !trickleSel);

  p_fault_status_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> statusN);

  p_timeout_latched_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd5 && enSync) |=> (mode == 3'd5));

  p_prog_fault_r11: assert property (@(posedge clk) disable iff (!rstN)
    (progSync && enSync && mode != 3'd5) |=> (!faultN && !chargeOn));

  p_disable_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enSync |=> (mode == 3'd0 && !chargeOn && statusN && faultN));

endmodule

bind chg_sequencer chg_sequencer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .oscTick    (oscTick),
  .enSync     (enSync),
  .progSync   (progSync),
  .mode       (mode),
  .chargeOn   (chargeOn),
  .trickleSel (trickleSel),
  .statusN    (statusN),
  .faultN     (faultN)
);

// File: tb/chg_sequencer_test.sv
`timescale 1ns/1ps
module chg_sequencer_test;

  localparam int TW = 8;
  localparam int QT = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic enableIn = 1'b1;
  logic atChargeV = 1'b0, aboveMin = 1'b0, belowRecharge = 1'b0;
  logic currentLow = 1'b0, progFault = 1'b0;
  logic [2:0] mode;
  logic chargeOn, trickleSel, statusN, faultN;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] m;
    logic on, tr, st, ft;
    string req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  chg_sequencer #(.TIMER_W(TW), .QUAL_TICKS(QT)) uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .enableIn(enableIn),
    .atChargeV(atChargeV), .aboveMin(aboveMin), .belowRecharge(belowRecharge),
    .currentLow(currentLow), .progFault(progFault),
    .mode(mode), .chargeOn(chargeOn), .trickleSel(trickleSel),
    .statusN(statusN), .faultN(faultN)
  );

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) oscTick = 1'b1;
      @(negedge clk) oscTick = 1'b0;
    end
    settle(3);
  endtask

  task automatic expect_out(input logic [2:0] m, input logic on, input logic tr,
                            input logic st, input logic ft, input string req);
    exp_t e;
    e.m = m; e.on = on; e.tr = tr; e.st = st; e.ft = ft; e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops expectations and compares them with the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        testCnt++;
        if (mode !== e.m || chargeOn !== e.on || trickleSel !== e.tr ||
            statusN !== e.st || faultN !== e.ft) begin
          failCnt++;
          $display("FAIL %s: got mode=%0d on=%b tr=%b stN=%b fN=%b, expected mode=%0d on=%b tr=%b stN=%b fN=%b",
                   e.req, mode, chargeOn, trickleSel, statusN, faultN,
                   e.m, e.on, e.tr, e.st, e.ft);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R1: idle under reset
    settle(2);
    expect_out(3'd0, 0, 0, 1, 1, "R1 reset");
    @(negedge clk) rstN = 1'b1;
    settle(5);
    expect_out(3'd1, 1, 1, 0, 1, "R2 start trickle after reset");

    // R3: interrupted run, then qualification
    aboveMin = 1'b1; settle(4);
    ticks(10);
    aboveMin = 1'b0; settle(4);
    ticks(1);
    aboveMin = 1'b1; settle(4);
    ticks(QT - 1);
    expect_out(3'd1, 1, 1, 0, 1, "R3 count restarted by bad tick");
    ticks(1);
    expect_out(3'd2, 1, 0, 0, 1, "R3 qualified into CC");

    // R5
    atChargeV = 1'b1; settle(4);
    expect_out(3'd3, 1, 0, 0, 1, "R5 CC to CV");

    // R7: low current but below recharge threshold
    currentLow = 1'b1; belowRecharge = 1'b1; settle(4);
    expect_out(3'd3, 1, 0, 0, 1, "R7 no EOC below recharge");

    // R6: EOC latch
    belowRecharge = 1'b0; settle(4);
    expect_out(3'd3, 1, 0, 1, 1, "R6 EOC raises status");
    currentLow = 1'b0; settle(4);
    expect_out(3'd3, 1, 0, 1, 1, "R6 EOC latched");

    // R8: timeout with EOC -> inhibit
    ticks((1 << TW) - 1);
    expect_out(3'd3, 1, 0, 1, 1, "R8 one tick before timeout");
    ticks(1);
    expect_out(3'd4, 0, 0, 1, 1, "R8 inhibit after timeout");

    // R10: recharge
    atChargeV = 1'b0; belowRecharge = 1'b1; settle(4);
    expect_out(3'd1, 1, 1, 0, 1, "R10 recharge restarts cycle");
    ticks(QT);
    expect_out(3'd2, 1, 0, 0, 1, "R10 back in CC");
    ticks((1 << TW) - 1);
    expect_out(3'd2, 1, 0, 0, 1, "R10 timer restarted");

    // R9: timeout without EOC
    ticks(1);
    expect_out(3'd5, 0, 0, 1, 0, "R9 timeout fault");
    progFault = 1'b1; settle(4);
    progFault = 1'b0; settle(4);
    ticks(3);
    expect_out(3'd5, 0, 0, 1, 0, "R9 fault stays latched");

    // R12: enable toggle clears it
    enableIn = 1'b0; settle(4);
    expect_out(3'd0, 0, 0, 1, 1, "R12 disable to idle");
    enableIn = 1'b1; settle(4);
    expect_out(3'd1, 1, 1, 0, 1, "R2 start on enable release");

    // R4: trickle limit
    belowRecharge = 1'b0; aboveMin = 1'b0; settle(4);
    ticks((1 << (TW - 3)) - 1);
    expect_out(3'd1, 1, 1, 0, 1, "R4 one tick before trickle limit");
    ticks(1);
    expect_out(3'd5, 0, 0, 1, 0, "R4 trickle timeout fault");

    enableIn = 1'b0; settle(4);
    enableIn = 1'b1; settle(4);

    // R11: program fault
    aboveMin = 1'b1; settle(4);
    ticks(QT);
    expect_out(3'd2, 1, 0, 0, 1, "R11 setup CC");
    progFault = 1'b1; settle(4);
    expect_out(3'd6, 0, 0, 1, 0, "R11 program fault");
    progFault = 1'b0; settle(4);
    expect_out(3'd1, 1, 1, 0, 1, "R11 auto resume in trickle");

    // R12 from trickle
    enableIn = 1'b0; settle(4);
    expect_out(3'd0, 0, 0, 1, 1, "R12 disable from trickle");

    settle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule